// File: doc/BRIEF.md
# Bufferless Deflection-Routed Multistage Packet Fabric

This block is a time-slotted switching fabric with twelve input ports and twelve output ports. It is built from thirty-six identical 2x2 nodes arranged as three concentric rings ("cylinders"), each with four heights and three angular positions. No node stores more than one packet, and the fabric has no queues. Every packet moves one hop per clock. From a node it either goes inward to the next ring at the same height, or sideways around its own ring to a new height. Each hop also advances the angle by one position.

The routing is bitwise. In each outer ring a node compares one address bit with the matching bit of its own height. The innermost ring compares the low address field with the node's angle and releases the packet to an output port. When two packets would land in one node, the packet already on the inner ring takes precedence. The node that would have sent the other packet inward receives a busy indication and sends its packet sideways instead. The outermost ring passes the same busy indication back to the input ports, and a blocked port holds its packet until the next slot.

Top module: `dvf_fabric`

## Requirements
- R1: Input port p feeds the outermost node at height p/3 and angle p%3. The 4-bit address carries the destination height in bits [3:2] and the destination angle (0 to 2) in bits [1:0]. The output port for an address is height*3 + angle.
- R2: While reset is asserted and right after it, no out_valid bit and no in_busy bit is high.
- R3: A packet is accepted on a rising edge only when its in_valid is high and its in_busy is low. A port whose in_busy is high keeps its packet, and that packet is taken on the first edge at which in_busy is low.
- R4: Every accepted packet leaves exactly once, on the output port its address names, with its address and tag unchanged.
- R5: A packet that meets no contention and whose entry height and angle already lead straight to its destination leaves 3 clock edges after entry, counting the accepting edge.
- R6: In the outermost ring, a packet whose address MSB differs from the MSB of the node's height moves sideways to the opposite half of the heights. For example, an address of 4'b1000 entering at port 0 leaves port 6 with a latency of 4.
- R7: In the innermost ring, a packet stays at its height and moves by one angle per slot until the angle equals address bits [1:0]. Port 0 with address 4'b0000 leaves port 0 with a latency of 4. Port 0 with address 4'b0001 leaves port 1 with a latency of 5.
- R8: in_busy[p] is high in exactly those slots in which an outermost-ring packet is moving sideways into port p's node. For example, one slot after port 0 accepts address 4'b1000, in_busy[7] is high.
- R9: No node ever receives two packets in one slot. A packet moving sideways on an inner ring takes precedence over an outer packet trying to enter the same node, and the outer packet is sent sideways. In the case provoked by the bench (port 5 sends 4'b0010, then port 0 sends 4'b0010 one slot later), the second packet leaves port 2 with a latency of 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock; one hop per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; empties every node |
| in_valid | input | 12 | Per-port packet present |
| in_addr | input | 48 | Per-port 4-bit destination address, port p at [4p+3:4p] |
| in_tag | input | 96 | Per-port 8-bit opaque tag, port p at [8p+7:8p] |
| in_busy | output | 12 | Per-port "entry node will be taken next slot": hold the packet |
| out_valid | output | 12 | Per-port packet leaving this slot |
| out_addr | output | 48 | Address of the leaving packet, same packing as in_addr |
| out_tag | output | 96 | Tag of the leaving packet, same packing as in_tag |

## Verification
Two events can fall in the same slot. One is a sideways move on a ring. The other is an ingress from the next ring out, or an injection at a port, aimed at the same node. The bench provokes the ring-to-ring case by offsetting two packets by exactly one slot so that their paths cross. It provokes the port case by offering a packet at the port whose node an outermost packet is about to enter. Both outcomes are judged only at the ports: by the busy bit seen in the contested slot, and by the exact exit cycle and exit port of each packet. Any wrong precedence would shift those values. A long mixed-traffic run then checks delivery of every packet exactly once, to the right port.

// File: rtl/dvf_pkg.sv
package dvf_pkg;

    // Height reached by a sideways hop on ring `cyl`. The outer rings flip the
    // height bit they test, so a mismatching packet lands on a matching height
    // one hop later. The innermost ring keeps the height.
    function automatic int dvf_cross(input int cyl, input int h, input int hb);
        if (cyl < hb) return h ^ (1 << (hb - 1 - cyl));
        return h;
    endfunction

endpackage

// File: rtl/dvf_decide.sv
module dvf_decide #(
    parameter int             AB       = 2,
    parameter bit             INNER    = 1'b0,
    parameter bit             HT_BIT   = 1'b0,
    parameter logic [AB-1:0]  ANG_BITS = '0
) (
    input  logic          vld,
    input  logic          hdr_bit,
    input  logic [AB-1:0] ang,
    input  logic          busy_in,
    output logic          go_south,
    output logic          go_east
);

    logic match;
    logic pass;

    always_comb begin
        match    = INNER ? (ang == ANG_BITS) : (hdr_bit == HT_BIT);
        pass     = match & ~busy_in;
        go_south = vld & pass;
        go_east  = vld & ~pass;
    end

endmodule

// File: rtl/dvf_node.sv
module dvf_node #(
    parameter int CYL_IDX = 0,
    parameter int HT_IDX  = 0,
    parameter int ANG_IDX = 0,
    parameter int HB      = 2,
    parameter int AB      = 2,
    parameter int TAG_W   = 8,
    localparam int AW     = HB + AB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             n_vld,
    input  logic [AW-1:0]    n_addr,
    input  logic [TAG_W-1:0] n_tag,
    input  logic             w_vld,
    input  logic [AW-1:0]    w_addr,
    input  logic [TAG_W-1:0] w_tag,
    input  logic             busy_in,
    output logic             q_vld,
    output logic [AW-1:0]    q_addr,
    output logic [TAG_W-1:0] q_tag,
    output logic             go_south,
    output logic             go_east
);

    localparam bit            INNER    = (CYL_IDX == HB);
    localparam logic [HB-1:0] HT_BITS  = HB'(HT_IDX);
    localparam int            HDR_POS  = INNER ? AW - 1 : AW - 1 - CYL_IDX;
    localparam int            HT_SHIFT = INNER ? 0 : HB - 1 - CYL_IDX;
    localparam bit            HT_BIT   = bit'((HT_IDX >> HT_SHIFT) & 1);
    localparam logic [AB-1:0] ANG_BITS = AB'(ANG_IDX);

    typedef struct packed {
        logic             vld;
        logic [AW-1:0]    addr;
        logic [TAG_W-1:0] tag;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = '0;
        if (n_vld) begin
            slot_d.vld  = 1'b1;
            slot_d.addr = n_addr;
            slot_d.tag  = n_tag;
        end else if (w_vld) begin
            slot_d.vld  = 1'b1;
            slot_d.addr = w_addr;
            slot_d.tag  = w_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign q_vld  = slot_q.vld;
    assign q_addr = slot_q.addr;
    assign q_tag  = slot_q.tag;

    dvf_decide #(
        .AB       (AB),
        .INNER    (INNER),
        .HT_BIT   (HT_BIT),
        .ANG_BITS (ANG_BITS)
    ) u_decide (
        .vld      (slot_q.vld),
        .hdr_bit  (slot_q.addr[HDR_POS]),
        .ang      (slot_q.addr[AB-1:0]),
        .busy_in  (busy_in),
        .go_south (go_south),
        .go_east  (go_east)
    );

    AST_SINGLE_OCCUPANT: assert property (@(posedge clk) disable iff (!rst_n)
        !(n_vld && w_vld)); // R9

    if (CYL_IDX > 0) begin : g_resolved
        AST_RESOLVED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
            slot_q.vld |-> (slot_q.addr[AW-1 -: CYL_IDX] == HT_BITS[HB-1 -: CYL_IDX])); // R4
    end

endmodule

// File: rtl/dvf_fabric.sv
module dvf_fabric
    import dvf_pkg::*;
#(
    parameter int  HEIGHTS = 4,
    parameter int  ANGLES  = 3,
    parameter int  TAG_W   = 8,
    localparam int HB      = $clog2(HEIGHTS),
    localparam int AB      = $clog2(ANGLES),
    localparam int AW      = HB + AB,
    localparam int NPORT   = HEIGHTS * ANGLES,
    localparam int CYLS    = HB + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT-1:0]       in_valid,
    input  logic [NPORT*AW-1:0]    in_addr,
    input  logic [NPORT*TAG_W-1:0] in_tag,
    output logic [NPORT-1:0]       in_busy,
    output logic [NPORT-1:0]       out_valid,
    output logic [NPORT*AW-1:0]    out_addr,
    output logic [NPORT*TAG_W-1:0] out_tag
);

    localparam int NODES = CYLS * NPORT;

    logic             node_vld  [CYLS][HEIGHTS][ANGLES];
    logic [AW-1:0]    node_addr [CYLS][HEIGHTS][ANGLES];
    logic [TAG_W-1:0] node_tag  [CYLS][HEIGHTS][ANGLES];
    logic             south     [CYLS][HEIGHTS][ANGLES];
    logic             east      [CYLS][HEIGHTS][ANGLES];

    for (genvar c = 0; c < CYLS; c++) begin : g_cyl
        for (genvar h = 0; h < HEIGHTS; h++) begin : g_ht
            for (genvar a = 0; a < ANGLES; a++) begin : g_ang
                localparam int AM1   = (a + ANGLES - 1) % ANGLES;
                localparam int W_SRC = dvf_cross(c, h, HB);
                localparam int PORT  = h * ANGLES + a;

                logic             n_vld;
                logic [AW-1:0]    n_addr;
                logic [TAG_W-1:0] n_tag;
                logic             busy_in;

                if (c == 0) begin : g_entry
                    assign in_busy[PORT] = east[0][W_SRC][AM1];
                    assign n_vld  = in_valid[PORT] & ~in_busy[PORT];
                    assign n_addr = in_addr[PORT*AW +: AW];
                    assign n_tag  = in_tag[PORT*TAG_W +: TAG_W];
                end else begin : g_ingress
                    assign n_vld  = south[c-1][h][AM1];
                    assign n_addr = node_addr[c-1][h][AM1];
                    assign n_tag  = node_tag[c-1][h][AM1];
                end

                if (c < CYLS - 1) begin : g_busy
                    assign busy_in = east[c+1][dvf_cross(c + 1, h, HB)][a];
                end else begin : g_nobusy
                    assign busy_in = 1'b0;
                end

                dvf_node #(
                    .CYL_IDX (c),
                    .HT_IDX  (h),
                    .ANG_IDX (a),
                    .HB      (HB),
                    .AB      (AB),
                    .TAG_W   (TAG_W)
                ) u_node (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .n_vld    (n_vld),
                    .n_addr   (n_addr),
                    .n_tag    (n_tag),
                    .w_vld    (east[c][W_SRC][AM1]),
                    .w_addr   (node_addr[c][W_SRC][AM1]),
                    .w_tag    (node_tag[c][W_SRC][AM1]),
                    .busy_in  (busy_in),
                    .q_vld    (node_vld[c][h][a]),
                    .q_addr   (node_addr[c][h][a]),
                    .q_tag    (node_tag[c][h][a]),
                    .go_south (south[c][h][a]),
                    .go_east  (east[c][h][a])
                );

                if (c == CYLS - 1) begin : g_exit
                    assign out_valid[PORT]               = south[c][h][a];
                    assign out_addr[PORT*AW +: AW]       = node_addr[c][h][a];
                    assign out_tag[PORT*TAG_W +: TAG_W]  = node_tag[c][h][a];

                    AST_EXIT_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
                        out_valid[PORT] |-> (out_addr[PORT*AW +: AW] == {HB'(h), AB'(a)})); // R4
                end
            end
        end
    end

    logic [NODES-1:0] occ_flat;
    logic [NPORT-1:0] acc_flat;

    always_comb begin
        for (int c = 0; c < CYLS; c++)
            for (int h = 0; h < HEIGHTS; h++)
                for (int a = 0; a < ANGLES; a++)
                    occ_flat[(c * HEIGHTS + h) * ANGLES + a] = node_vld[c][h][a];
        acc_flat = in_valid & ~in_busy;
    end

    AST_PACKET_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(occ_flat) == $past($countones(occ_flat))
                  + $past($countones(acc_flat)) - $past($countones(out_valid)))); // R4

endmodule

// File: tb/dvf_fabric_bench.sv
module dvf_fabric_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 12;
    localparam int AW = 4;
    localparam int TW = 8;
    localparam int FIRST_STRESS = 20;
    localparam int LAST_STRESS  = 220;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     in_valid = '0;
    logic [NP*AW-1:0]  in_addr = '0;
    logic [NP*TW-1:0]  in_tag = '0;
    logic [NP-1:0]     in_busy;
    logic [NP-1:0]     out_valid;
    logic [NP*AW-1:0]  out_addr;
    logic [NP*TW-1:0]  out_tag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int dcnt [256];
    int dport[256];
    int dcyc [256];
    int daddr[256];
    int saddr[256];
    int sport[256];

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dvf_fabric u_dvf_fabric (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .in_tag    (in_tag),
        .in_busy   (in_busy),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_tag   (out_tag)
    );

    initial for (int i = 0; i < 256; i++) begin
        dcnt[i] = 0; dport[i] = -1; dcyc[i] = -1; daddr[i] = -1; saddr[i] = -1; sport[i] = -1;
    end

    // exit log, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                if (out_valid[p]) begin
                    int t;
                    t = int'(out_tag[p*TW +: TW]);
                    dcnt[t]  = dcnt[t] + 1;
                    dport[t] = p;
                    dcyc[t]  = cyc;
                    daddr[t] = int'(out_addr[p*AW +: AW]);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int p, input int addr, input int tag);
        in_addr[p*AW +: AW] = AW'(addr);
        in_tag[p*TW +: TW]  = TW'(tag);
        in_valid[p]         = 1'b1;
        saddr[tag]          = addr;
        sport[tag]          = (addr >> 2) * 3 + (addr & 3);
    endtask

    task automatic clr(input int p);
        in_valid[p] = 1'b0;
    endtask

    task automatic expect_pkt(input int tag, input int port, input int lat,
                              input int acc_edge, input string req);
        check(dcnt[tag] == 1, req, $sformatf("deliveries of tag %0d", tag), dcnt[tag], 1);
        check(dport[tag] == port, req, $sformatf("exit port of tag %0d", tag), dport[tag], port);
        check(daddr[tag] == saddr[tag], req, $sformatf("exit address of tag %0d", tag),
              daddr[tag], saddr[tag]);
        if (lat > 0)
            check(dcyc[tag] - acc_edge + 1 == lat, req,
                  $sformatf("latency of tag %0d", tag), dcyc[tag] - acc_edge + 1, lat);
    endtask

    task automatic single(input int p, input int addr, input int tag,
                          input int lat, input string req);
        int n;
        @(negedge clk);
        n = cyc;
        put(p, addr, tag);
        check(in_busy[p] == 1'b0, "R3", "entry busy on idle fabric", int'(in_busy[p]), 0);
        @(negedge clk);
        clr(p);
        repeat (12) @(negedge clk);
        expect_pkt(tag, sport[tag], lat, n + 1, req);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(out_valid == '0, "R2", "out_valid after reset", int'(out_valid), 0);
        check(in_busy == '0, "R2", "in_busy after reset", int'(in_busy), 0);
    endtask

    task automatic test_straight();
        single(0, 4'b0010, 1, 3, "R5");   // port 0 -> port 2
        single(11, 4'b1101, 2, 3, "R5");  // port 11 -> port 10
        check(sport[1] == 2 && sport[2] == 10, "R1", "port map of test packets",
              sport[1] * 100 + sport[2], 210);
    endtask

    task automatic test_outer_mismatch();
        single(0, 4'b1000, 3, 4, "R6");   // crosses to the lower half, exits port 6
    endtask

    task automatic test_circulate();
        single(0, 4'b0000, 4, 4, "R7");
        single(0, 4'b0001, 5, 5, "R7");
    endtask

    task automatic test_busy_back();
        int n;
        @(negedge clk);
        n = cyc;
        put(0, 4'b1000, 6);
        @(negedge clk);
        clr(0);
        check(in_busy[7] == 1'b1, "R8", "busy toward port 7 while neighbour moves in",
              int'(in_busy[7]), 1);
        put(7, 4'b1001, 7);
        @(negedge clk);
        check(in_busy[7] == 1'b0, "R8", "busy toward port 7 one slot later",
              int'(in_busy[7]), 0);
        @(negedge clk);
        clr(7);
        repeat (12) @(negedge clk);
        expect_pkt(6, 6, 4, n + 1, "R8");
        expect_pkt(7, 7, 4, n + 3, "R3");  // held one slot, taken on edge n+3
    endtask

    task automatic test_deflect();
        int n;
        @(negedge clk);
        n = cyc;
        put(5, 4'b0010, 8);
        @(negedge clk);
        clr(5);
        check(in_busy[0] == 1'b0, "R9", "entry busy for second packet", int'(in_busy[0]), 0);
        put(0, 4'b0010, 9);
        @(negedge clk);
        clr(0);
        repeat (14) @(negedge clk);
        expect_pkt(8, 2, 4, n + 1, "R9");  // inner packet keeps its path
        expect_pkt(9, 2, 6, n + 2, "R9");  // outer packet sent sideways
    endtask

    task automatic test_stress();
        logic [15:0]   lfsr = 16'hACE1;
        logic [NP-1:0] pend = '0;
        logic [NP-1:0] busy_prev = '0;
        int next_tag = FIRST_STRESS;
        while (next_tag < LAST_STRESS || pend != '0) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++)
                if (pend[p] && !busy_prev[p]) begin
                    pend[p] = 1'b0;
                    clr(p);
                end
            for (int p = 0; p < NP; p++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (!pend[p] && next_tag < LAST_STRESS && lfsr[0]) begin
                    put(p, int'(lfsr[3:2]) * 4 + int'(lfsr[7:4]) % 3, next_tag);
                    pend[p] = 1'b1;
                    next_tag++;
                end
            end
            busy_prev = in_busy;
        end
        repeat (40) @(negedge clk);
        for (int t = FIRST_STRESS; t < LAST_STRESS; t++)
            expect_pkt(t, sport[t], 0, 0, "R4");
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == '0, "R2", "out_valid during reset", int'(out_valid), 0);
        rst_n = 1'b1;
        test_reset();
        test_straight();
        test_outer_mismatch();
        test_circulate();
        test_busy_back();
        test_deflect();
        test_stress();
        finish_run();
    end

endmodule